// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address sequence for a synchronous burst memory. A start address is registered on a rising clock edge whenever the chip enable is active and either of two independent address strobes is high. After that load, the two low address bits are driven by an internal 2-bit burst count. The count steps only on cycles where the advance input is high, so a burst covers four word addresses. The upper address bits keep the loaded value until the next load.

An order-select input picks how the low bits walk through the aligned group of four. In linear order they are the start bits plus the count, modulo 4. In interleaved order they are the start bits XOR the count. Interleaved order is the tie-off state, so an undriven select (pulled low) gives interleaved bursts.

Bursting is optional. A new address can be loaded on every cycle, back to back, and no cycle is lost. Strobes that arrive while the chip enable is low start nothing.

Top module: `burst_addr_seq`

## Requirements
- R1: On a rising edge where chip_en is 1 and strobe_a or strobe_b is 1, the block registers addr_in. After that edge addr_out equals addr_in and burst_idx is 0.
- R2: A strobe that arrives while chip_en is 0 loads nothing. If advance is also 0, addr_out and burst_idx keep their values.
- R3: On an edge with no load and advance = 1, burst_idx increments by one modulo 4, so 3 wraps to 0.
- R4: On an edge with no load and advance = 0, burst_idx holds its value.
- R5: A load has priority over advance. This holds when both strobes and advance are high in the same cycle: the count restarts at 0.
- R6: With order_sel = 1 (linear), addr_out[1:0] = (start[1:0] + burst_idx) mod 4. For example, start 10 gives 10, 11, 00, 01.
- R7: With order_sel = 0 (interleaved, the tie-off default), addr_out[1:0] = start[1:0] XOR burst_idx. For example, start 01 gives 01, 00, 11, 10.
- R8: addr_out bits above bit 1 change only on a load edge.
- R9: Loads on consecutive cycles each take effect. Every cycle shows the address presented one edge earlier.
- R10: While rst_n is low, addr_out and burst_idx are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Decoded chip enable that qualifies both strobes |
| strobe_a | input | 1 | First address strobe |
| strobe_b | input | 1 | Second address strobe |
| advance | input | 1 | Steps the burst count when no load occurs |
| order_sel | input | 1 | 1 = linear order, 0 = interleaved order (default) |
| addr_in | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Current word address |
| burst_idx | output | 2 | Position within the current burst |

## Verification
The hardest case to reach is a burst that wraps past its fourth beat while the order mode changes, with a deselected strobe arriving in the middle of it. To get there, the stimulus loads a start address whose low bits are non-zero. It then advances five times, so the count passes 3 and returns to 0. Along the way it inserts hold cycles and a strobe with chip_en low. Later it switches order_sel during an open burst without reloading. A scoreboard model predicts the address for every cycle. The stimulus also covers simultaneous strobes combined with advance, and a run of eight back-to-back loads.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en,
  input  logic              strobe_a,
  input  logic              strobe_b,
  input  logic              advance,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic [1:0]        burst_idx
);

  localparam int CNT_W = 2;

  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  low_bits;
  logic              load;

  assign load = chip_en & (strobe_a | strobe_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      base_q <= addr_in;
      cnt_q  <= '0;
    end else if (advance) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign low_bits  = order_sel ? (base_q[CNT_W-1:0] + cnt_q)
                               : (base_q[CNT_W-1:0] ^ cnt_q);
  assign addr_out  = {base_q[ADDR_W-1:CNT_W], low_bits};
  assign burst_idx = cnt_q;

  assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (addr_out == $past(addr_in)) && (burst_idx == 2'd0));

  assert_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_en && !advance) |=> $stable(burst_idx) &&
      ((order_sel != $past(order_sel)) || $stable(addr_out)));

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && advance) |=> burst_idx == 2'($past(burst_idx) + 2'd1));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !advance) |=> $stable(burst_idx));

  assert_load_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && advance) |=> burst_idx == 2'd0);

  assert_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(addr_out[ADDR_W-1:CNT_W]));

endmodule

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          chip_en = 1'b0, strobe_a = 1'b0, strobe_b = 1'b0;
  logic          advance = 1'b0, order_sel = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic [1:0]    burst_idx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt  = '0;

  logic [AW-1:0] q_addr[$];
  logic [1:0]    q_idx[$];
  string         q_tag[$];

  always #2.5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .strobe_a(strobe_a),
    .strobe_b(strobe_b), .advance(advance), .order_sel(order_sel),
    .addr_in(addr_in), .addr_out(addr_out), .burst_idx(burst_idx)
  );

  function automatic logic [AW-1:0] expect_addr(logic [AW-1:0] b, logic [1:0] c, logic lin);
    logic [1:0] lo;
    lo = lin ? 2'(b[1:0] + c) : (b[1:0] ^ c);
    return {b[AW-1:2], lo};
  endfunction

  task automatic step(input logic ce, input logic sa, input logic sb,
                      input logic adv, input logic lin,
                      input logic [AW-1:0] a, input string tag);
    @(negedge clk);
    chip_en = ce; strobe_a = sa; strobe_b = sb;
    advance = adv; order_sel = lin; addr_in = a;
    if (ce && (sa || sb)) begin
      m_base = a;
      m_cnt  = 2'd0;
    end else if (adv) begin
      m_cnt = m_cnt + 2'd1;
    end
    q_addr.push_back(expect_addr(m_base, m_cnt, lin));
    q_idx.push_back(m_cnt);
    q_tag.push_back(tag);
  endtask

  task automatic check(input bit ok, input string tag, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always begin
    @(posedge clk);
    #2;
    if (q_addr.size() > 0) begin
      logic [AW-1:0] ea;
      logic [1:0]    ei;
      string         t;
      ea = q_addr.pop_front();
      ei = q_idx.pop_front();
      t  = q_tag.pop_front();
      check(addr_out == ea, {t, " addr"}, addr_out, ea);
      check(burst_idx == ei, {t, " idx"}, AW'(burst_idx), AW'(ei));
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(addr_out == '0, "R10 addr", addr_out, '0);
    check(burst_idx == 2'd0, "R10 idx", AW'(burst_idx), '0);
    rst_n = 1'b1;

    // R1 load via strobe_a, R7 interleaved 01,00,11,10 then wrap (R3)
    step(1, 1, 0, 0, 0, 20'h12341, "R1 load");
    step(0, 0, 0, 1, 0, 20'h0, "R7 beat1");
    step(0, 0, 0, 0, 0, 20'h0, "R4 hold");
    step(0, 0, 0, 1, 0, 20'h0, "R7 beat2");
    step(0, 1, 0, 0, 0, 20'hABCDE, "R2 deselected strobe");
    step(0, 0, 0, 1, 0, 20'h0, "R7 beat3");
    step(0, 0, 0, 1, 0, 20'h0, "R3 wrap");
    step(0, 0, 1, 1, 0, 20'h55555, "R2 deselected with advance");

    // R6 linear via strobe_b, start 10
    step(1, 0, 1, 0, 1, 20'hF0F02, "R1 load strobe_b");
    for (int i = 0; i < 5; i++) step(0, 0, 0, 1, 1, 20'h0, "R6 linear beat");
    step(0, 0, 0, 0, 1, 20'h0, "R4 hold linear");

    // order change mid-burst, R8 upper stable
    step(0, 0, 0, 1, 0, 20'h0, "R8 mode switch interleaved");
    step(0, 0, 0, 0, 1, 20'h0, "R8 mode switch linear");

    // R5 both strobes with advance
    step(1, 1, 1, 1, 0, 20'h00003, "R5 load priority");
    step(1, 1, 0, 1, 0, 20'h00007, "R5 reload over advance");
    step(0, 0, 0, 1, 0, 20'h0, "R7 start 11");

    // R9 back-to-back loads
    for (int i = 0; i < 8; i++)
      step(1, i[0], ~i[0], i[1], i[2], AW'(32'h9E3B7 * (i + 1)), "R9 back-to-back");
    step(0, 0, 0, 0, 0, 20'h0, "R4 idle");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule